// File: doc/BRIEF.md
# Period-Match Timer with Clock-Domain Synchronizers

The block is an 8-bit up-counter. It advances on edges of an external timer input, scaled by a programmable prescaler. Each time the count has reached a programmed period value, the next counting pulse wraps it back to zero. Every wrap raises a one-cycle match pulse in the system clock domain.

The timer input is a free-running signal with no fixed relation to the system clock. It is sampled by a two-stage synchronizer and edge-detected, and a polarity bit chooses which edge counts. Two further options make starting, stopping and reading cleaner:
- The enable bit can be passed through a two-stage chain that advances only on counting edges. Turning the timer on or off then never produces a partial count.
- The prescaler output can be given an extra register stage, so that a read of the count always returns a settled value.

Software uses a small write/read register port to set the control bits, the prescale ratio and the period, and to load or read the count.

Top module: `ptmr_top`

## Requirements
- R1: After reset, the control word, the period and the count all read back as zero, and the match output is low.
- R2: Polarity bit 0 selects the rising edge of the timer input as the counting edge, and polarity bit 1 selects the falling edge. The other edge has no effect.
- R3: While the enable bit is 1, writes to the polarity bit are ignored, and the control register reads back the old polarity.
- R4: With enable synchronization on, the first two active edges after enabling are not counted, and two active edges after disabling are still counted. With it off, counting follows the enable bit directly.
- R5: The prescaler divides active edges by 2^ps, where ps is the 3-bit field (1 to 128). The prescaler is cleared when the enable bit is written from 0 to 1.
- R6: When the count equals the period, the next counting pulse sets the count to zero and drives match_o high for exactly one system cycle. A count run of P pulses from zero therefore ends at P mod (period+1), with P div (period+1) match pulses.
- R7: While the timer is stopped, active edges leave the count unchanged.
- R8: A write to the count register takes effect on the next cycle and clears the prescaler.
- R9: With ps=0 and no enable synchronization, the count changes 3 system clock edges after the timer input changes level, or 4 edges when prescaler synchronization is on.
- R10: Register map. Address 0 is control: bit0 enable, bit1 polarity, bit2 enable sync, bit3 prescaler sync, bits 6:4 ps, bit7 reads 0. Address 1 is the period, address 2 is the count, and address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_in | input | 1 | Asynchronous timer input clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| match_o | output | 1 | One-cycle period-match pulse |

## Verification
Each level change on the timer input takes three system edges to reach the count, and four when prescaler synchronization is on. The latency checks therefore drive the input at a falling clock edge and sample the count after exactly that many edges. In the sweeps and directed cases, each level is held for three cycles and the bench waits several idle cycles before reading. All pending pulses have then settled, and the expected count is computed as (edges >> ps) mod (period+1), with the match pulses counted on every falling edge. A register write shows on the read port one cycle later, so read-back checks sample just after the next falling edge.

// File: rtl/ptmr_pkg.sv
// Shared register addresses and control-word layout for the period-match timer.
package ptmr_pkg;
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;

    // Control word, bit 0 is enable; ps occupies bits 6:4.
    typedef struct packed {
        logic [2:0] ps;
        logic       ps_sync;
        logic       en_sync;
        logic       pol;
        logic       en;
    } ctrl_t;
endpackage

// File: rtl/ptmr_edge.sv
// Synchronizes the asynchronous timer input into the system clock domain and
// emits a one-cycle tick on the edge chosen by pol (0 rising, 1 falling).
// Assumes the input holds each level for at least one system cycle.
module ptmr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_in,
    input  logic pol,
    output logic tick
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0] sh;
    logic                 rise;
    logic                 fall;

    // Shift the raw input through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else begin
            sh <= {sh[SYNC_STAGES-1:0], tmr_in};
        end
    end

    // Compare synchronized level against its previous value.
    always_comb begin
        rise = sh[LAST] & ~sh[SYNC_STAGES];
        fall = ~sh[LAST] & sh[SYNC_STAGES];
        tick = pol ? fall : rise;
    end

    // Two active edges need a level change in between.
    p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && $stable(pol)) |=> !tick);
endmodule

// File: rtl/ptmr_ensync.sv
// Produces the run qualifier. With sync_on set the enable bit travels through
// a DELAY-stage chain that advances only on counting-clock ticks, so starting
// and stopping lag by DELAY active edges; otherwise run follows en directly.
module ptmr_ensync #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic sync_on,
    output logic run
);
    logic [DELAY-1:0] chain;

    // Advance the enable chain on each counting-clock tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (tick) begin
            chain[0] <= en;
            for (int i = 1; i < DELAY; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    // Select synchronized or direct enable.
    always_comb run = sync_on ? chain[DELAY-1] : en;

    // With sync on, run may only move on a tick.
    p_sync_run_moves_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_on && !tick) |=> (!sync_on || $stable(run)));
endmodule

// File: rtl/ptmr_prescale.sv
// Power-of-two prescaler: divides qualified ticks by 2^sel and optionally
// registers the output pulse once more in the system domain. clr has priority.
module ptmr_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            adv,
    input  logic [PS_W-1:0] sel,
    input  logic            sync_on,
    output logic            pulse
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] mask;
    logic             hit;
    logic             hit_q;

    // Terminal-count mask for the selected ratio (wraps to all ones at max).
    always_comb begin
        mask = (DIV_W'(1) << sel) - DIV_W'(1);
        hit  = adv && ((pcnt & mask) == mask);
    end

    // Count qualified ticks, restarting after each output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (adv) begin
            pcnt <= hit ? '0 : pcnt + DIV_W'(1);
        end
    end

    // Optional output register for a settled count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit;
        end
    end

    always_comb pulse = sync_on ? hit_q : hit;

    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pcnt == '0));
endmodule

// File: rtl/ptmr_core.sv
// Count register with period compare. A write has priority over a step; a
// step at count == period wraps to zero and raises match for one cycle.
module ptmr_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    // Update the count and generate the match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            match <= 1'b0;
        end else begin
            match <= 1'b0;
            if (wr) begin
                cnt <= wr_val;
            end else if (step) begin
                if (cnt == period) begin
                    cnt   <= '0;
                    match <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    p_wrap_on_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr && cnt == period) |=> (cnt == '0 && match));
    p_match_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> !match);
    p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr) |=> $stable(cnt));
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt == $past(wr_val)));
endmodule

// File: rtl/ptmr_top.sv
// Period-match timer top: register port, input edge selection, enable
// synchronizer, prescaler and count/compare core. Single system clock,
// synchronous active-low reset; tmr_in may be asynchronous.
module ptmr_top
    import ptmr_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PS_W        = 3,
    parameter int SYNC_STAGES = 2,
    parameter int EN_DELAY    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             match_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             run;
    logic             step;
    logic             wr_ctrl;
    logic             wr_cnt;
    logic             en_rise;

    // Decode write strobes and the enable 0->1 event.
    always_comb begin
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        wr_cnt  = wr_en && (wr_addr == ADDR_COUNT);
        en_rise = wr_ctrl && wr_data[0] && !ctrl.en;
    end

    // Control and period registers; polarity is locked while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl   <= '0;
            period <= '0;
        end else if (wr_ctrl) begin
            ctrl.en      <= wr_data[0];
            ctrl.pol     <= ctrl.en ? ctrl.pol : wr_data[1];
            ctrl.en_sync <= wr_data[2];
            ctrl.ps_sync <= wr_data[3];
            ctrl.ps      <= wr_data[4 +: PS_W];
        end else if (wr_en && wr_addr == ADDR_PERIOD) begin
            period <= wr_data;
        end
    end

    ptmr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tmr_in (tmr_in),
        .pol    (ctrl.pol),
        .tick   (tick)
    );

    ptmr_ensync #(.DELAY(EN_DELAY)) u_ensync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .en      (ctrl.en),
        .sync_on (ctrl.en_sync),
        .run     (run)
    );

    ptmr_prescale #(.PS_W(PS_W)) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (en_rise || wr_cnt),
        .adv     (tick && run),
        .sel     (ctrl.ps),
        .sync_on (ctrl.ps_sync),
        .pulse   (step)
    );

    ptmr_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .wr     (wr_cnt),
        .wr_val (wr_data),
        .period (period),
        .cnt    (cnt),
        .match  (match_o)
    );

    // Register read mux.
    always_comb begin
        case (rd_addr)
            ADDR_CTRL:   rd_data = CNT_W'(ctrl);
            ADDR_PERIOD: rd_data = period;
            ADDR_COUNT:  rd_data = cnt;
            default:     rd_data = '0;
        endcase
    end

    p_pol_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && ctrl.en) |=> $stable(ctrl.pol));
endmodule

// File: tb/test_ptmr_top.sv
`timescale 1ns/1ps
module test_ptmr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       match_o;

    int nchk = 0;
    int nerr = 0;
    int mcount = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ptmr_top i_ptmr_top (
        .clk(clk), .rst_n(rst_n), .tmr_in(tmr_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .match_o(match_o)
    );

    always @(negedge clk) if (rst_n && match_o) mcount++;

    task automatic check(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output int v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic edges(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tmr_in = 1'b1;
            repeat (3) @(negedge clk);
            tmr_in = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // cfg bits: 1 pol, 2 en_sync, 3 ps_sync, 6:4 ps; bit 0 enable.
    task automatic sweep_case(int pol, int es, int pss, int ps, int per, int n);
        int v;
        int p;
        logic [7:0] cfg;
        cfg = 8'((pol << 1) | (es << 2) | (pss << 3) | (ps << 4));
        wr(2'd0, cfg);
        wr(2'd1, 8'(per));
        wr(2'd2, 8'd0);
        mcount = 0;
        wr(2'd0, cfg | 8'd1);
        edges(n);
        wr(2'd0, cfg);
        edges(2);
        settle();
        p = n >> ps;
        rd(2'd2, v);
        check("R6 count", v, p % (per + 1));
        check("R6 matches", mcount, p / (per + 1));
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 period", v, 0);
        rd(2'd2, v); check("R1 count", v, 0);
        check("R1 match", int'(match_o), 0);

        // R10 register map
        wr(2'd0, 8'hFE); @(negedge clk);
        rd(2'd0, v); check("R10 ctrl readback", v, 8'h7E);
        wr(2'd1, 8'hA5); @(negedge clk);
        rd(2'd1, v); check("R10 period readback", v, 8'hA5);
        rd(2'd3, v); check("R10 unused addr", v, 0);

        // R9 latency, with and without prescaler sync
        for (int s = 0; s < 2; s++) begin
            wr(2'd0, 8'(s << 3));
            wr(2'd1, 8'hFF);
            wr(2'd2, 8'd0);
            wr(2'd0, 8'((s << 3) | 1));
            rd_addr = 2'd2;
            @(negedge clk); tmr_in = 1'b1;
            repeat (3) @(negedge clk);
            #1 check("R9 after 3 edges", int'(rd_data), (s == 1) ? 0 : 1);
            @(negedge clk);
            #1 check("R9 after 4 edges", int'(rd_data), 1);
            tmr_in = 1'b0;
            settle();
            wr(2'd0, 8'(s << 3));
        end

        // R2 falling-edge polarity
        wr(2'd0, 8'h02); wr(2'd1, 8'hFF); wr(2'd2, 8'd0); wr(2'd0, 8'h03);
        @(negedge clk); tmr_in = 1'b1; settle();
        rd(2'd2, v); check("R2 rise ignored with pol=1", v, 0);
        tmr_in = 1'b0; settle();
        rd(2'd2, v); check("R2 fall counted with pol=1", v, 1);
        // R3 polarity write while enabled is ignored
        wr(2'd0, 8'h01); @(negedge clk);
        rd(2'd0, v); check("R3 pol locked", v, 8'h03);
        tmr_in = 1'b1; settle();
        rd(2'd2, v); check("R3 rise still ignored", v, 1);
        tmr_in = 1'b0; settle();
        rd(2'd2, v); check("R3 fall still counted", v, 2);
        wr(2'd0, 8'h00);
        // R2 rising-edge polarity
        wr(2'd2, 8'd0); wr(2'd0, 8'h01);
        @(negedge clk); tmr_in = 1'b1; settle();
        rd(2'd2, v); check("R2 rise counted with pol=0", v, 1);
        tmr_in = 1'b0; settle();
        rd(2'd2, v); check("R2 fall ignored with pol=0", v, 1);
        wr(2'd0, 8'h00);
        // R7 stopped timer ignores edges
        edges(3); settle();
        rd(2'd2, v); check("R7 hold while stopped", v, 1);

        // R4 enable synchronization delay
        wr(2'd0, 8'h04); wr(2'd2, 8'd0); wr(2'd0, 8'h05);
        edges(2); settle();
        rd(2'd2, v); check("R4 first two edges skipped", v, 0);
        edges(1); settle();
        rd(2'd2, v); check("R4 third edge counted", v, 1);
        wr(2'd0, 8'h04);
        edges(1); settle();
        rd(2'd2, v); check("R4 counts after disable", v, 2);
        edges(3); settle();
        rd(2'd2, v); check("R4 R7 stopped after two", v, 3);

        // R5 prescaler cleared on enable rise (ps=2)
        wr(2'd0, 8'h20); wr(2'd2, 8'd0); wr(2'd0, 8'h21);
        edges(3);
        wr(2'd0, 8'h20); wr(2'd0, 8'h21);
        edges(3); settle();
        rd(2'd2, v); check("R5 cleared on enable", v, 0);
        edges(1); settle();
        rd(2'd2, v); check("R5 fourth edge", v, 1);
        // R8 count write is immediate and clears prescaler
        edges(3);
        wr(2'd2, 8'd5);
        rd(2'd2, v); check("R8 write immediate", v, 5);
        edges(3); settle();
        rd(2'd2, v); check("R8 prescaler cleared", v, 5);
        wr(2'd0, 8'h20);

        // R5 R6 sweep over configuration
        for (int pol = 0; pol < 2; pol++)
            for (int es = 0; es < 2; es++)
                for (int pss = 0; pss < 2; pss++)
                    for (int k = 0; k < 4; k++) begin
                        int ps;
                        ps = (k == 3) ? 5 : k;
                        sweep_case(pol, es, pss, ps, 2 + ((k + pol) % 4),
                                   (1 << ps) * 7 + 3);
                    end
        sweep_case(0, 0, 0, 0, 0, 5);
        sweep_case(1, 1, 1, 7, 1, 300);
        sweep_case(0, 0, 1, 0, 255, 40);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule